// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

A synchronous static RAM model in which each enabled rising clock edge accepts one command. Address, control and write data are all registered, and the read and write paths have the same pipeline depth. A read returns its word on the data bus two enabled edges after the command. A write takes its data from the bus two enabled edges after the command. Because the two latencies match, reads and writes can alternate on every cycle without an idle slot for bus turnaround.

A command either loads a new address (read, write or deselect) or continues a four-beat burst from the last loaded address. A continue cycle repeats the type of the previous operation. A static input selects linear or interleaved burst ordering. Per-lane write enables are taken when a write address is loaded and apply to every beat of that burst. An active-low clock enable freezes the whole device. An asynchronous output enable gates only the output drivers. The bidirectional data bus is split into separate input, output and output-enable ports. The address width is a parameter, set small by default for simulation (17 bits for the full-size array), and so are the lane count and the lane width.

Top module: `zbt_sram`

## Requirements
- R1: After reset the outputs are quiet: dataOutEn is 0 and dataOut is 0.
- R2: While clkEnN is 1, rising edges have no effect: dataOut and dataOutEn stay unchanged, the pending pipeline stays frozen, and the command, address and data inputs present during such edges change no stored word.
- R3: The chip is enabled only when sel1N is 0, sel2 is 1 and sel3N is 0. A load cycle (advance 0) with the chip disabled is a deselect: it writes nothing, even with writeN low, and its output slot is not driven.
- R4: A load read (advance 0, chip enabled, writeN 1) presents the addressed word on dataOut with dataOutEn 1 (when outEnN is 0) after the second enabled edge following the command. A load write (writeN 0) stores dataIn sampled at the second enabled edge following the command.
- R5: byteEnN is active low. Bit i gates lane i, which is dataIn bits [i*9 +: 9]. A write with all bits 1 still loads the address but changes nothing. When writeN is 1 the cycle is a read, whatever the value of byteEnN.
- R6: With advance 1 the cycle continues the previous operation type (read, write or deselect). sel1N, sel2, sel3N, writeN and byteEnN are ignored in that cycle. Beats of a write burst use the lane enables captured at its load.
- R7: Burst beat n (n = 0 at the load) keeps the address bits above bit 1 and sets bits [1:0] to (base + n) mod 4 when burstInterleave is 0, or to base XOR n when it is 1. The sequence wraps after four beats.
- R8: A deselect command stops output driving two enabled edges after it. A continue following a deselect is again a deselect.
- R9: Reads and writes can be issued on consecutive cycles with no gap. The bus is not driven in a write's data slot. A read issued right after a write to the same address returns the new value merged lane by lane with the old word.
- R10: outEnN acts asynchronously. While it is 1, dataOutEn is 0. It does not alter dataOut or the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| clkEnN | input | 1 | Active-low clock enable; 1 freezes the device |
| sel1N | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3N | input | 1 | Chip select, active low |
| writeN | input | 1 | 0 = write, 1 = read on a load cycle |
| byteEnN | input | LANES | Active-low lane write enables |
| advance | input | 1 | 1 = continue burst, 0 = load new address |
| addr | input | ADDR_W | Word address |
| burstInterleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| outEnN | input | 1 | Asynchronous active-low output enable |
| dataIn | input | LANES*LANE_W | Data bus, inbound half |
| dataOut | output | LANES*LANE_W | Data bus, outbound half |
| dataOutEn | output | 1 | Drive enable for dataOut |

## Verification
The hardest case to produce is a read that reaches the array while an older write to the same word is still waiting for its bus data. The case is harder still when the write is partial and clock-enable holds stretch the pipeline in between. The stimulus issues write-then-read pairs to one address on back-to-back cycles with mixed lane masks. It then runs a long random mix of loads, continues, deselects and holds. A scoreboard models the array in command order and predicts every read slot and idle slot.

// File: rtl/zbt_pkg.sv
`timescale 1ns/100ps
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_e;

  typedef enum logic [2:0] {
    CY_HOLD  = 3'd0,
    CY_DESEL = 3'd1,
    CY_LDRD  = 3'd2,
    CY_LDWR  = 3'd3,
    CY_CONT  = 3'd4
  } cycleKind_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic stall;      // edge is frozen
    logic rdCapture;  // stage-1 read samples the array
    logic commit;     // stage-2 write stores bus data
    logic outLoad;    // stage-2 read loads the output register
  } strobes_t;

endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/100ps
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEnN,
  input  logic              sel1N,
  input  logic              sel2,
  input  logic              sel3N,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteEnN,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burstInterleave,
  output strobes_t          stb,
  output logic [ADDR_W-1:0] rdIdx,
  output logic [ADDR_W-1:0] wrIdx,
  output logic [LANES-1:0]  wrLane
);

  cycleKind_e        kind;
  opKind_e           s1Op, s2Op, nextOp;
  logic [ADDR_W-1:0] s1Idx, s2Idx, nextAddr, baseAddr;
  logic [LANES-1:0]  s1Lane, s2Lane, nextLane;
  logic [1:0]        beat, burstLow;
  logic              chipOn;

  assign chipOn = !sel1N && sel2 && !sel3N;

  always_comb begin
    if (clkEnN)       kind = CY_HOLD;
    else if (advance) kind = CY_CONT;
    else if (!chipOn) kind = CY_DESEL;
    else if (!writeN) kind = CY_LDWR;
    else              kind = CY_LDRD;
  end

  assign burstLow = burstInterleave ? (baseAddr[1:0] ^ beat)
                                    : (baseAddr[1:0] + beat);

  always_comb begin
    nextOp   = s1Op;
    nextAddr = {baseAddr[ADDR_W-1:2], burstLow};
    nextLane = s1Lane;
    unique case (kind)
      CY_DESEL: begin nextOp = OP_NONE;  nextAddr = addr; nextLane = '0;       end
      CY_LDRD:  begin nextOp = OP_READ;  nextAddr = addr; nextLane = '0;       end
      CY_LDWR:  begin nextOp = OP_WRITE; nextAddr = addr; nextLane = ~byteEnN; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Op     <= OP_NONE;
      s2Op     <= OP_NONE;
      s1Idx    <= '0;
      s2Idx    <= '0;
      s1Lane   <= '0;
      s2Lane   <= '0;
      baseAddr <= '0;
      beat     <= 2'd1;
    end else if (kind != CY_HOLD) begin
      s1Op   <= nextOp;
      s1Idx  <= nextAddr;
      s1Lane <= nextLane;
      s2Op   <= s1Op;
      s2Idx  <= s1Idx;
      s2Lane <= s1Lane;
      if (kind == CY_CONT) begin
        beat <= beat + 2'd1;
      end else begin
        baseAddr <= addr;
        beat     <= 2'd1;
      end
    end
  end

  always_comb begin
    stb.stall     = clkEnN;
    stb.rdCapture = (s1Op == OP_READ);
    stb.commit    = (s2Op == OP_WRITE);
    stb.outLoad   = (s2Op == OP_READ);
  end

  assign rdIdx  = s1Idx;
  assign wrIdx  = s2Idx;
  assign wrLane = s2Lane;

  AST_HOLD_PIPE: assert property (@(posedge clk) disable iff (rst)
    clkEnN |=> ($stable(s1Op) && $stable(s2Op) && $stable(s1Idx))); // R2

  AST_CONT_KEEPS_TYPE: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && advance) |=> (s1Op == $past(s1Op))); // R6

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && advance && !burstInterleave) |=>
      (s1Idx[1:0] == $past(s1Idx[1:0]) + 2'd1)); // R7

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && advance) |=> (s1Idx[ADDR_W-1:2] == $past(s1Idx[ADDR_W-1:2]))); // R7

endmodule

// File: rtl/zbt_datapath.sv
`timescale 1ns/100ps
module zbt_datapath
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  strobes_t                  stb,
  input  logic [ADDR_W-1:0]         rdIdx,
  input  logic [ADDR_W-1:0]         wrIdx,
  input  logic [LANES-1:0]          wrLane,
  input  logic [LANES*LANE_W-1:0]   dataIn,
  input  logic                      outEnN,
  output logic [LANES*LANE_W-1:0]   dataOut,
  output logic                      dataOutEn
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdWord, merged, holdWord, doutReg;
  logic              driveReg, hitPending;

  assign rdWord     = mem[rdIdx];
  assign hitPending = stb.commit && (wrIdx == rdIdx);

  // lane-wise forwarding of a write whose data is arriving this edge
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign merged[g*LANE_W +: LANE_W] = (hitPending && wrLane[g])
                                        ? dataIn[g*LANE_W +: LANE_W]
                                        : rdWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst && !stb.stall && stb.commit) begin
      for (int i = 0; i < LANES; i++) begin
        if (wrLane[i]) mem[wrIdx][i*LANE_W +: LANE_W] <= dataIn[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdWord <= '0;
      doutReg  <= '0;
      driveReg <= 1'b0;
    end else if (!stb.stall) begin
      if (stb.rdCapture) holdWord <= merged;
      if (stb.outLoad)   doutReg  <= holdWord;
      driveReg <= stb.outLoad;
    end
  end

  assign dataOut   = doutReg;
  assign dataOutEn = driveReg && !outEnN;

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    stb.stall |=> ($stable(doutReg) && $stable(driveReg))); // R2

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!stb.stall && stb.outLoad) |=> driveReg); // R4

  AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!stb.stall && stb.commit) |=> !dataOutEn); // R9

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!stb.stall && !stb.outLoad && !stb.commit) |=> !dataOutEn); // R8

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/100ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clkEnN,
  input  logic                    sel1N,
  input  logic                    sel2,
  input  logic                    sel3N,
  input  logic                    writeN,
  input  logic [LANES-1:0]        byteEnN,
  input  logic                    advance,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burstInterleave,
  input  logic                    outEnN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);

  strobes_t          stb;
  logic [ADDR_W-1:0] rdIdx, wrIdx;
  logic [LANES-1:0]  wrLane;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) uCtrl (
    .clk(clk), .rst(rst), .clkEnN(clkEnN),
    .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
    .writeN(writeN), .byteEnN(byteEnN), .advance(advance),
    .addr(addr), .burstInterleave(burstInterleave),
    .stb(stb), .rdIdx(rdIdx), .wrIdx(wrIdx), .wrLane(wrLane)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rst(rst), .stb(stb),
    .rdIdx(rdIdx), .wrIdx(wrIdx), .wrLane(wrLane),
    .dataIn(dataIn), .outEnN(outEnN),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

endmodule

// File: tb/sim_zbt_sram.sv
`timescale 1ns/100ps
module sim_zbt_sram;

  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int WW = LN * LW;
  localparam int DP = 1 << AW;

  localparam int K_DESEL = 0;
  localparam int K_READ  = 1;
  localparam int K_WRITE = 2;
  localparam int K_CONT  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkEnN = 1'b0, sel1N = 1'b1, sel2 = 1'b0, sel3N = 1'b1, writeN = 1'b1;
  logic [LN-1:0] byteEnN = '1;
  logic advance = 1'b0;
  logic [AW-1:0] addr = '0;
  logic burstInterleave = 1'b0;
  logic outEnN = 1'b0;
  logic [WW-1:0] dataIn = '0;
  logic [WW-1:0] dataOut;
  logic dataOutEn;

  always #2 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .clkEnN(clkEnN),
    .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N), .writeN(writeN),
    .byteEnN(byteEnN), .advance(advance), .addr(addr),
    .burstInterleave(burstInterleave), .outEnN(outEnN),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  typedef struct {
    int            kind;
    logic [WW-1:0] exp;
    string         tag;
    bit            oeTest;
  } item_t;

  item_t         expQ[$];
  logic [WW-1:0] refMem [DP];
  logic [AW-1:0] bBase = '0;
  logic [1:0]    bBeat = 2'd1;
  int            lastKind = K_DESEL;
  logic [LN-1:0] lastLane = '0;
  logic [WW-1:0] wdPipe0 = '0, wdPipe1 = '0;
  int            nTests = 0, nFail = 0;
  bit            monOn = 0, finished = 0;

  function automatic logic [WW-1:0] junkWord();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[WW-1:0];
  endfunction

  function automatic logic [WW-1:0] pat(input logic [AW-1:0] a);
    return {1'b1, a, 1'b0, ~a, 1'b1, a ^ 8'h5A, 1'b0, a + 8'd3};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one enabled command per call
  task automatic issue(input int kind, input logic [AW-1:0] a, input logic [LN-1:0] beN,
                       input logic [WW-1:0] wd, input string tag,
                       input int dMode = 0, input bit oeT = 0);
    item_t it;
    int eff;
    logic [AW-1:0] ea;
    logic [LN-1:0] lanes;
    logic [1:0] low;
    @(negedge clk);
    clkEnN  = 1'b0;
    byteEnN = beN;
    addr    = a;
    if (kind == K_CONT) begin
      advance = 1'b1;
      eff     = lastKind;
      low     = burstInterleave ? (bBase[1:0] ^ bBeat) : (bBase[1:0] + bBeat);
      ea      = {bBase[AW-1:2], low};
      bBeat   = bBeat + 2'd1;
      lanes   = lastLane;
      sel1N   = 1'($urandom_range(0, 1));
      sel2    = 1'($urandom_range(0, 1));
      sel3N   = 1'($urandom_range(0, 1));
      writeN  = 1'($urandom_range(0, 1));
    end else begin
      advance = 1'b0;
      bBase = a; bBeat = 2'd1; ea = a;
      sel1N = 1'b0; sel2 = 1'b1; sel3N = 1'b0;
      if (kind == K_DESEL) begin
        eff = K_DESEL; writeN = 1'b0; lanes = '0;
        if (dMode == 0) sel1N = 1'b1;
        else if (dMode == 1) sel2 = 1'b0;
        else sel3N = 1'b1;
      end else if (kind == K_READ) begin
        eff = K_READ; writeN = 1'b1; lanes = '0;
      end else begin
        eff = K_WRITE; writeN = 1'b0; lanes = ~beN;
      end
      lastLane = lanes;
    end
    lastKind = eff;
    dataIn  = wdPipe1;
    wdPipe1 = wdPipe0;
    wdPipe0 = (eff == K_WRITE) ? wd : junkWord();
    it.kind = eff; it.tag = tag; it.oeTest = oeT; it.exp = '0;
    if (eff == K_WRITE) begin
      for (int i = 0; i < LN; i++)
        if (lanes[i]) refMem[ea][i*LW +: LW] = wd[i*LW +: LW];
    end else if (eff == K_READ) begin
      it.exp = refMem[ea];
    end
    expQ.push_back(it);
  endtask

  // frozen edges with a live-looking write command on the inputs
  task automatic hold(input int n, input logic [AW-1:0] a);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      clkEnN = 1'b1; advance = 1'b0; sel1N = 1'b0; sel2 = 1'b1; sel3N = 1'b0;
      writeN = 1'b0; byteEnN = '0; addr = a; dataIn = junkWord();
    end
  endtask

  // monitor: pops the command two enabled edges old and compares
  initial begin
    item_t it;
    bit enAtEdge;
    logic [WW-1:0] lastOut;
    logic lastEn;
    wait (monOn);
    lastOut = dataOut;
    lastEn  = dataOutEn;
    forever begin
      @(posedge clk);
      enAtEdge = !clkEnN;
      #0.5;
      if (enAtEdge) begin
        if (expQ.size() > 2) begin
          it = expQ.pop_front();
          if (it.kind == K_READ) begin
            chk(dataOutEn === 1'b1, it.tag, "read slot drive", 64'(dataOutEn), 64'd1);
            chk(dataOut === it.exp, it.tag, "read data", 64'(dataOut), 64'(it.exp));
            if (it.oeTest) begin
              outEnN = 1'b1;
              #0.5;
              chk(dataOutEn === 1'b0, "R10", "drive with outEnN high", 64'(dataOutEn), 64'd0);
              chk(dataOut === it.exp, "R10", "data with outEnN high", 64'(dataOut), 64'(it.exp));
              outEnN = 1'b0;
              #0.5;
              chk(dataOutEn === 1'b1, "R10", "drive restored", 64'(dataOutEn), 64'd1);
            end
          end else begin
            chk(dataOutEn === 1'b0, (it.kind == K_WRITE) ? "R9" : "R8",
                "idle slot drive", 64'(dataOutEn), 64'd0);
          end
        end
      end else begin
        chk(dataOut === lastOut && dataOutEn === lastEn, "R2", "hold stability",
            64'({dataOutEn, dataOut}), 64'({lastEn, lastOut}));
      end
      lastOut = dataOut;
      lastEn  = dataOutEn;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dataOutEn === 1'b0, "R1", "reset drive", 64'(dataOutEn), 64'd0);
    chk(dataOut === '0, "R1", "reset data", 64'(dataOut), 64'd0);
    rst = 1'b0;
    monOn = 1;

    // fill the array with aligned linear write bursts
    burstInterleave = 1'b0;
    for (int b = 0; b < DP; b += 4) begin
      issue(K_WRITE, AW'(b), 4'h0, pat(AW'(b)), "R4");
      for (int k = 1; k < 4; k++)
        issue(K_CONT, AW'($urandom), LN'($urandom), pat(AW'(b + k)), "R6");
    end

    // linear read burst from an unaligned start: 11,12,13,10
    issue(K_READ, 8'h11, 4'h0, '0, "R7");
    for (int k = 0; k < 3; k++) issue(K_CONT, '0, '0, '0, "R7");

    // interleaved read burst from 26: 27,24,25 then wrap to 26
    issue(K_DESEL, 8'h00, '1, '0, "R8");
    burstInterleave = 1'b1;
    issue(K_READ, 8'h26, 4'h0, '0, "R7");
    for (int k = 0; k < 4; k++) issue(K_CONT, '0, '0, '0, "R7");

    // interleaved write burst with two lanes, then read it back
    issue(K_WRITE, 8'h42, 4'b1001, junkWord(), "R6");
    for (int k = 0; k < 3; k++) issue(K_CONT, '0, 4'h0, junkWord(), "R6");
    issue(K_DESEL, 8'h00, '1, '0, "R8", 1);
    burstInterleave = 1'b0;
    for (int k = 0; k < 4; k++) issue(K_READ, AW'(8'h40 + k), '0, '0, "R6");

    // back-to-back alternation with forwarding
    issue(K_READ, 8'h30, '0, '0, "R9");
    issue(K_WRITE, 8'h31, 4'h0, junkWord(), "R9");
    issue(K_READ, 8'h31, '0, '0, "R9");
    issue(K_WRITE, 8'h30, 4'b1010, junkWord(), "R9");
    issue(K_READ, 8'h30, '0, '0, "R9");
    issue(K_WRITE, 8'h70, 4'b0101, junkWord(), "R9");
    issue(K_READ, 8'h70, 4'h0, '0, "R9");

    // lane enables, zero-lane write and zero-lane burst
    issue(K_WRITE, 8'h50, 4'b1110, junkWord(), "R5");
    issue(K_WRITE, 8'h51, 4'b1111, junkWord(), "R5");
    issue(K_WRITE, 8'h58, 4'b1111, junkWord(), "R5");
    for (int k = 0; k < 3; k++) issue(K_CONT, '0, 4'h0, junkWord(), "R5");
    issue(K_DESEL, 8'h00, '1, '0, "R8", 2);
    issue(K_READ, 8'h50, 4'h0, '0, "R5");
    issue(K_READ, 8'h51, 4'h0, '0, "R5");
    for (int k = 0; k < 4; k++) issue(K_READ, AW'(8'h58 + k), 4'h0, '0, "R5");

    // deselect variants carrying a write request, then continues
    issue(K_DESEL, 8'h60, 4'h0, junkWord(), "R3", 0);
    issue(K_DESEL, 8'h61, 4'h0, junkWord(), "R3", 1);
    issue(K_DESEL, 8'h62, 4'h0, junkWord(), "R3", 2);
    issue(K_CONT, '0, 4'h0, junkWord(), "R8");
    issue(K_CONT, '0, 4'h0, junkWord(), "R8");
    for (int k = 0; k < 4; k++) issue(K_READ, AW'(8'h60 + k), '0, '0, "R3");

    // holds in the middle of the pipeline with a bogus write presented
    issue(K_READ, 8'h64, '0, '0, "R2");
    hold(3, 8'h63);
    issue(K_READ, 8'h65, '0, '0, "R2");
    hold(1, 8'h63);
    issue(K_WRITE, 8'h66, 4'b0110, junkWord(), "R2");
    hold(2, 8'h63);
    issue(K_READ, 8'h66, '0, '0, "R2");
    issue(K_READ, 8'h63, '0, '0, "R2");

    // asynchronous output enable
    issue(K_READ, 8'h12, '0, '0, "R4", 0, 1);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3)       issue(K_READ, AW'($urandom), LN'($urandom), '0, "R4");
      else if (r < 6)  issue(K_WRITE, AW'($urandom), LN'($urandom), junkWord(), "R4");
      else if (r < 8)  issue(K_CONT, AW'($urandom), LN'($urandom), junkWord(), "R6");
      else if (r == 8) issue(K_DESEL, AW'($urandom), LN'($urandom), junkWord(), "R3",
                             $urandom_range(0, 2));
      else             hold($urandom_range(1, 2), AW'($urandom));
    end

    for (int k = 0; k < 4; k++) issue(K_DESEL, 8'h00, '1, '0, "R8");
    @(negedge clk);
    chk(dataOutEn === 1'b0, "R8", "final release", 64'(dataOutEn), 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule